// File: doc/BRIEF.md
# Single-Cell Charge Sequencer

This block is the digital sequencer of a linear single-cell lithium charger. Analog comparators, already synchronized to the clock, report the battery and current levels, whether the supply is present and whether the pack temperature is in range. From these inputs the block picks one of four current settings for the regulator: off, a small trickle, precharge or full fast-charge. It also raises a done flag when charging ends and a fault flag when a safety condition occurs.

A charge cycle starts with conditioning when the cell is deeply discharged. It then moves to fast charge, where the constant-current and constant-voltage parts are handled by the analog loop. The cycle ends on the minimum-current level, on a taper timer, or on a backup fast-charge timer. All timers count a 1 Hz tick, and their lengths are parameters. A cell that later sags below the recharge level starts a new cycle by itself. Loss of the supply, after a deglitch delay, puts the block to sleep. An enable input stops charging. A second enable input turns off the fast-charge timer, the taper timer and the minimum-current termination.

Top module: `chg_seq`

## Requirements
- R1: While rst_ni is low, mode_o is 0, done_o is 0 and fault_o is 0, and the sequencer is idle.
- R2: mode_o is 2 bits wide: 0 is off, 1 is trickle, 2 is precharge and 3 is fast-charge. done_o and fault_o are active high. All three outputs are registered and change one clock after the state change that causes them.
- R3: When charge enable goes high in idle, the block enters conditioning if bat_lt_lowv_i is high, and fast charge otherwise. In conditioning, mode is trickle (1) while bat_lt_sc_i is high and precharge (2) while it is low.
- R4: When PRE_TICKS ticks are counted in conditioning with the temperature in range, the block enters fault. In fault, fault_o is 1 and mode is trickle (1). The fault stays set while the battery level changes.
- R5: In conditioning, bat_lt_lowv_i going low moves the block to fast charge (mode 3).
- R6: With tmr_en_i high, FAST_TICKS ticks counted in fast charge end the cycle (done).
- R7: With tmr_en_i high, TAPER_TICKS consecutive ticks counted while bat_at_reg_i and cur_lt_taper_i are both high end the cycle. If either flag drops, the taper count clears.
- R8: With tmr_en_i high, bat_at_reg_i and cur_lt_term_i both high in fast charge end the cycle on the next clock.
- R9: When the cycle has ended, mode is off and done_o is 1. bat_lt_rch_i going high returns the block to idle, and a new cycle then starts.
- R10: With tmr_en_i low, the fast-charge timer, the taper timer and termination have no effect, and fast charge continues.
- R11: With temp_ok_i low, the mode is off in conditioning and fast charge, and no timer advances.
- R12: chg_en_i low returns the block to idle from any awake state with the mode off. This clears a fault.
- R13: supply_ok_i low for SLEEP_DGL_CYC consecutive clocks forces sleep from any state, with mode off and both flags low. A shorter low pulse has no effect. supply_ok_i high leaves sleep for idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_ok_i | input | 1 | Supply sufficiently above battery (sleep comparator, hysteresis outside) |
| bat_lt_sc_i | input | 1 | Battery below short-circuit level |
| bat_lt_lowv_i | input | 1 | Battery below conditioning-exit level |
| bat_lt_rch_i | input | 1 | Battery below recharge level |
| bat_at_reg_i | input | 1 | Battery at regulation voltage |
| cur_lt_taper_i | input | 1 | Charge current below taper level |
| cur_lt_term_i | input | 1 | Charge current below termination level |
| temp_ok_i | input | 1 | Pack temperature inside the allowed window |
| chg_en_i | input | 1 | Charge enable |
| tmr_en_i | input | 1 | Enables fast/taper timers and current termination |
| tick_i | input | 1 | One-cycle pulse at 1 Hz |
| mode_o | output | 2 | Current setting: 0 off, 1 trickle, 2 precharge, 3 fast |
| done_o | output | 1 | Charge cycle complete |
| fault_o | output | 1 | Conditioning timeout fault |

## Verification
The bench first takes a deeply discharged cell through the trickle and precharge levels to a conditioning timeout. This separates a fault from a normal exit, and a temperature excursion during this phase shows whether the timer holds while out of range. It then ends fast charge in each of three ways: by the backup timer, by the minimum-current level, and by a taper window that is broken once and then completed. This tells the three end conditions apart. It repeats the same stimulus with the timer enable low to show that none of them can end the cycle. Finally, supply drops shorter than and equal to the deglitch window separate a glitch from a real sleep.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_FAST  = 3'd2,
    ST_DONE  = 3'd3,
    ST_FAULT = 3'd4,
    ST_SLEEP = 3'd5
  } chg_state_e;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_TRICKLE = 2'd1,
    MODE_PRE     = 2'd2,
    MODE_FAST    = 2'd3
  } chg_mode_e;
endpackage

// File: rtl/chg_sleep_dgl.sv
module chg_sleep_dgl #(
  parameter int unsigned DGL_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  output logic sleep_trig_o
);
  localparam int unsigned W = $clog2(DGL_CYC + 1);
  localparam logic [W-1:0] LAST = W'(DGL_CYC - 1);

  logic [W-1:0] cnt_q;

  assign sleep_trig_o = !supply_ok_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (supply_ok_i) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/chg_tick_timer.sv
module chg_tick_timer #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic exp_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  // expiry on the tick that would make the count reach LIMIT
  assign exp_o = run_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (run_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/chg_seq_fsm.sv
module chg_seq_fsm
  import chg_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_trig_i,
  input  logic       supply_ok_i,
  input  logic       chg_en_i,
  input  logic       tmr_en_i,
  input  logic       temp_ok_i,
  input  logic       bat_lt_sc_i,
  input  logic       bat_lt_lowv_i,
  input  logic       bat_lt_rch_i,
  input  logic       bat_at_reg_i,
  input  logic       cur_lt_term_i,
  input  logic       pre_exp_i,
  input  logic       fast_exp_i,
  input  logic       taper_exp_i,
  output chg_state_e state_o,
  output logic [1:0] mode_o,
  output logic       done_o,
  output logic       fault_o
);
  chg_state_e state_q, state_d;
  chg_mode_e  mode_d;
  logic       term_hit;

  assign term_hit = tmr_en_i && bat_at_reg_i && cur_lt_term_i;

  always_comb begin
    state_d = state_q;
    if (sleep_trig_i) begin
      state_d = ST_SLEEP;
    end else if (state_q == ST_SLEEP) begin
      if (supply_ok_i) state_d = ST_IDLE;
    end else if (!chg_en_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  state_d = bat_lt_lowv_i ? ST_PRE : ST_FAST;
        ST_PRE: begin
          if (!bat_lt_lowv_i) state_d = ST_FAST;
          else if (pre_exp_i) state_d = ST_FAULT;
        end
        ST_FAST: begin
          if (fast_exp_i || taper_exp_i || term_hit) state_d = ST_DONE;
        end
        ST_DONE:  if (bat_lt_rch_i) state_d = ST_IDLE;
        ST_FAULT: state_d = ST_FAULT;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PRE:   mode_d = !temp_ok_i ? MODE_OFF : (bat_lt_sc_i ? MODE_TRICKLE : MODE_PRE);
      ST_FAST:  mode_d = temp_ok_i ? MODE_FAST : MODE_OFF;
      ST_FAULT: mode_d = MODE_TRICKLE;
      default:  mode_d = MODE_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_o  <= MODE_OFF;
      done_o  <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_o  <= mode_d;
      done_o  <= (state_q == ST_DONE);
      fault_o <= (state_q == ST_FAULT);
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/chg_seq.sv
module chg_seq
  import chg_seq_pkg::*;
#(
  parameter int unsigned PRE_TICKS     = 2065,
  parameter int unsigned FAST_TICKS    = 20650,
  parameter int unsigned TAPER_TICKS   = 2065,
  parameter int unsigned SLEEP_DGL_CYC = 20_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       supply_ok_i,
  input  logic       bat_lt_sc_i,
  input  logic       bat_lt_lowv_i,
  input  logic       bat_lt_rch_i,
  input  logic       bat_at_reg_i,
  input  logic       cur_lt_taper_i,
  input  logic       cur_lt_term_i,
  input  logic       temp_ok_i,
  input  logic       chg_en_i,
  input  logic       tmr_en_i,
  input  logic       tick_i,
  output logic [1:0] mode_o,
  output logic       done_o,
  output logic       fault_o
);
  chg_state_e state_w;
  logic sleep_trig, pre_exp, fast_exp, taper_exp;
  logic in_pre, in_fast, taper_cond, live_tick;

  assign in_pre     = (state_w == ST_PRE);
  assign in_fast    = (state_w == ST_FAST);
  assign taper_cond = in_fast && bat_at_reg_i && cur_lt_taper_i;
  assign live_tick  = tick_i && temp_ok_i;  // R11: out-of-window temperature freezes timers

  chg_sleep_dgl #(.DGL_CYC(SLEEP_DGL_CYC)) u_dgl (
    .clk_i, .rst_ni, .supply_ok_i, .sleep_trig_o(sleep_trig)
  );

  chg_tick_timer #(.LIMIT(PRE_TICKS)) u_pre_tmr (
    .clk_i, .rst_ni, .clr_i(!in_pre), .run_i(in_pre && live_tick), .exp_o(pre_exp)
  );

  chg_tick_timer #(.LIMIT(FAST_TICKS)) u_fast_tmr (
    .clk_i, .rst_ni, .clr_i(!in_fast),
    .run_i(in_fast && live_tick && tmr_en_i), .exp_o(fast_exp)
  );

  chg_tick_timer #(.LIMIT(TAPER_TICKS)) u_taper_tmr (
    .clk_i, .rst_ni, .clr_i(!taper_cond),
    .run_i(taper_cond && live_tick && tmr_en_i), .exp_o(taper_exp)
  );

  chg_seq_fsm u_fsm (
    .clk_i, .rst_ni,
    .sleep_trig_i(sleep_trig),
    .supply_ok_i, .chg_en_i, .tmr_en_i, .temp_ok_i,
    .bat_lt_sc_i, .bat_lt_lowv_i, .bat_lt_rch_i, .bat_at_reg_i, .cur_lt_term_i,
    .pre_exp_i(pre_exp), .fast_exp_i(fast_exp), .taper_exp_i(taper_exp),
    .state_o(state_w),
    .mode_o, .done_o, .fault_o
  );
endmodule

// File: rtl/chg_seq_chk.sv
module chg_seq_chk
  import chg_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       chg_en_i,
  input logic       temp_ok_i,
  input chg_state_e state_i,
  input logic [1:0] mode_o,
  input logic       done_o,
  input logic       fault_o
);
  p_fault_trickle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> mode_o == MODE_TRICKLE);

  p_done_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (mode_o == MODE_OFF && !fault_o));

  p_en_low_off_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chg_en_i |=> ##1 (mode_o == MODE_OFF && !fault_o && !done_o));

  p_temp_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == ST_PRE || state_i == ST_FAST) && !temp_ok_i) |=> mode_o == MODE_OFF);

  p_sleep_quiet_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SLEEP) |=> (mode_o == MODE_OFF && !done_o && !fault_o));

  p_fault_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FAULT && chg_en_i && $past(state_i) == ST_FAULT) |-> fault_o);
endmodule

bind chg_seq chg_seq_chk u_chk (
  .clk_i, .rst_ni, .chg_en_i, .temp_ok_i,
  .state_i(state_w), .mode_o, .done_o, .fault_o
);

// File: tb/sim_chg_seq.sv
module sim_chg_seq;
  localparam int PRE = 5, FAST = 12, TAPER = 4, DGL = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sup, sc, lowv, rch, at_reg, taper, term, temp, en, tte, tick;
  logic [1:0] mode;
  logic done, fault;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  chg_seq #(.PRE_TICKS(PRE), .FAST_TICKS(FAST), .TAPER_TICKS(TAPER), .SLEEP_DGL_CYC(DGL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(sup), .bat_lt_sc_i(sc), .bat_lt_lowv_i(lowv),
    .bat_lt_rch_i(rch), .bat_at_reg_i(at_reg), .cur_lt_taper_i(taper), .cur_lt_term_i(term),
    .temp_ok_i(temp), .chg_en_i(en), .tmr_en_i(tte), .tick_i(tick),
    .mode_o(mode), .done_o(done), .fault_o(fault)
  );

  // behavioural reference: 0 idle 1 cond 2 fast 3 done 4 fault 5 sleep
  int m_st, m_nx, m_pre, m_fast, m_tap, m_dgl;
  bit trig, pre_x, fast_x, tap_x, tcond;
  logic [1:0] e_mode;
  logic e_done, e_fault;
  string e_tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_pre = 0; m_fast = 0; m_tap = 0; m_dgl = 0;
      e_mode = 0; e_done = 0; e_fault = 0; e_tag = "R1";
    end else begin
      case (m_st)
        1: begin e_mode = !temp ? 2'd0 : (sc ? 2'd1 : 2'd2); e_tag = "R3"; end
        2: begin e_mode = temp ? 2'd3 : 2'd0; e_tag = "R6"; end
        3: begin e_mode = 0; e_tag = "R9"; end
        4: begin e_mode = 1; e_tag = "R4"; end
        5: begin e_mode = 0; e_tag = "R13"; end
        default: begin e_mode = 0; e_tag = "R12"; end
      endcase
      e_done = (m_st == 3);
      e_fault = (m_st == 4);
      trig = !sup && m_dgl == DGL - 1;
      if (sup) m_dgl = 0; else if (m_dgl < DGL - 1) m_dgl++;
      tcond = (m_st == 2) && at_reg && taper;
      pre_x = (m_st == 1) && tick && temp && m_pre == PRE - 1;
      fast_x = (m_st == 2) && tick && temp && tte && m_fast == FAST - 1;
      tap_x = tcond && tick && temp && tte && m_tap == TAPER - 1;
      m_nx = m_st;
      if (trig) m_nx = 5;
      else if (m_st == 5) begin if (sup) m_nx = 0; end
      else if (!en) m_nx = 0;
      else case (m_st)
        0: m_nx = lowv ? 1 : 2;
        1: if (!lowv) m_nx = 2; else if (pre_x) m_nx = 4;
        2: if (fast_x || tap_x || (tte && at_reg && term)) m_nx = 3;
        3: if (rch) m_nx = 0;
        default: ;
      endcase
      if (m_st != 1) m_pre = 0; else if (tick && temp) m_pre++;
      if (m_st != 2) m_fast = 0; else if (tick && temp && tte) m_fast++;
      if (!tcond) m_tap = 0; else if (tick && temp && tte) m_tap++;
      m_st = m_nx;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (mode !== e_mode || done !== e_done || fault !== e_fault) begin
        n_bad++;
        $display("FAIL %s model: actual mode=%0d done=%0b fault=%0b expected mode=%0d done=%0b fault=%0b",
                 e_tag, mode, done, fault, e_mode, e_done, e_fault);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; cyc(1); tick = 1'b0; cyc(1);
    end
  endtask

  task automatic chk(input logic [1:0] m, input logic d, input logic f, input string tag);
    n_chk++;
    if (mode !== m || done !== d || fault !== f) begin
      n_bad++;
      $display("FAIL %s: actual mode=%0d done=%0b fault=%0b expected mode=%0d done=%0b fault=%0b",
               tag, mode, done, fault, m, d, f);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    sup = 1; sc = 1; lowv = 1; rch = 1; at_reg = 0; taper = 0; term = 0;
    temp = 1; en = 0; tte = 1; tick = 0;
    cyc(3);
    chk(0, 0, 0, "R1 reset");
    rst_n = 1'b1;
    cyc(2);
    chk(0, 0, 0, "R1 idle after reset");

    en = 1; cyc(2);
    chk(1, 0, 0, "R3 trickle below sc");
    sc = 0; cyc(2);
    chk(2, 0, 0, "R3 precharge");
    pulse_tick(PRE - 1);
    temp = 0; cyc(2);
    chk(0, 0, 0, "R11 temp out, mode off");
    pulse_tick(3);
    temp = 1; cyc(2);
    chk(2, 0, 0, "R11 timer held while temp out");
    pulse_tick(1);
    chk(1, 0, 1, "R4 precharge timeout fault");
    lowv = 0; cyc(3);
    chk(1, 0, 1, "R4 fault sticky");

    en = 0; cyc(2);
    chk(0, 0, 0, "R12 enable low clears fault");
    lowv = 1; en = 1; cyc(2);
    chk(2, 0, 0, "R3 re-enter conditioning");
    lowv = 0; cyc(2);
    chk(3, 0, 0, "R5 fast after lowv clears");

    rch = 0;
    pulse_tick(FAST - 1);
    chk(3, 0, 0, "R6 fast before timer end");
    pulse_tick(1);
    chk(0, 1, 0, "R6 fast timer ends cycle");
    cyc(3);
    chk(0, 1, 0, "R9 done holds");
    rch = 1; cyc(3);
    chk(3, 0, 0, "R9 recharge restart");

    rch = 0; at_reg = 1; term = 1; cyc(2);
    chk(0, 1, 0, "R8 termination");
    term = 0; at_reg = 0; rch = 1; cyc(3);
    chk(3, 0, 0, "R9 restart after termination");
    rch = 0;

    tte = 0; at_reg = 1; term = 1; taper = 1;
    pulse_tick(FAST + 2);
    chk(3, 0, 0, "R10 timers and termination disabled");

    tte = 1; term = 0;
    pulse_tick(TAPER - 1);
    taper = 0; pulse_tick(1); taper = 1;
    pulse_tick(TAPER - 1);
    chk(3, 0, 0, "R7 taper count cleared by break");
    pulse_tick(1);
    chk(0, 1, 0, "R7 taper timer ends cycle");

    at_reg = 0; taper = 0; rch = 1; cyc(3);
    chk(3, 0, 0, "R9 restart for sleep test");
    sup = 0; cyc(DGL - 1); sup = 1; cyc(3);
    chk(3, 0, 0, "R13 short supply dip ignored");
    sup = 0; cyc(DGL + 1);
    chk(0, 0, 0, "R13 sleep after deglitch");
    sup = 1; cyc(4);
    chk(3, 0, 0, "R13 wake to charge");

    en = 0; cyc(2);
    chk(0, 0, 0, "R12 enable low stops fast");
    chk(2'(u0.mode_o), u0.done_o, u0.fault_o, "R2 output width");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule